// File: doc/BRIEF.md
# Boundary Scan Test Access Controller

This block is the serial test logic of a small device. A sixteen-state controller follows the test mode select line on each rising edge of the test clock. A four-bit instruction register, selected through that controller, chooses which data register is placed between the serial input and the serial output: a one-bit bypass stage, a 32-bit identification word, or a boundary scan chain that spans every device pin.

The boundary chain has three cells per pin: the pin's input level, the core's output value and the core's output enable. It can snapshot all of them and shift them out. It also holds an update stage, which drives the pin outputs and enables only while the external-test instruction is in force. For as long as that instruction stays active, the core is held in reset. Under every other instruction the pins follow the core, and the test logic leaves the system untouched.

Top module: `jtag_tdp`

## Requirements
- R1: Test reset input low forces the controller to Test-Logic-Reset at once, without waiting for a clock edge. In that state the core reset output is low and the pins follow the core.
- R2: Five rising clock edges with test mode select high reach Test-Logic-Reset from any state. The instruction then falls back to the identification code 0010, or to all ones when no identification register is built.
- R3: The instruction register is 4 bits wide and shifts least significant bit first. It loads the pattern 0001 in Capture-IR, and its active value changes on the falling clock edge in Update-IR. The codes are 0000 external test, 0001 sample/preload, 0010 identification and 1111 bypass.
- R4: Under bypass, a single cell loads 0 in Capture-DR and loads the serial input only on a Shift-DR rising edge. The serial output is therefore the input delayed by one shift, led by a 0.
- R5: Any instruction code not listed in R3 behaves exactly as bypass.
- R6: Under the identification instruction, Capture-DR loads the 32-bit parameter word, whose bit 0 is 1. It is shifted out least significant bit first.
- R7: Under external test and sample/preload, Capture-DR loads the chain with bits [N-1:0] from the pin inputs, bits [2N-1:N] from the core outputs and bits [3N-1:2N] from the core enables. Bit 0 leaves first.
- R8: Under sample/preload, the chain is captured, shifted and updated while the pin outputs and enables keep following the core and the core reset output stays low.
- R9: While external test is the active instruction, the core reset output is high. The pin outputs take update-stage bits [2N-1:N] and the enables take bits [3N-1:2N], both loaded on the falling edge in Update-DR.
- R10: The serial output and its enable change only on falling clock edges. The enable is high only in Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| core_out | input | NPINS | Output values from the core logic |
| core_oe | input | NPINS | Output enables from the core logic |
| pin_in | input | NPINS | Levels seen on the device pins |
| pin_out | output | NPINS | Values driven to the pins |
| pin_oe | output | NPINS | Drive enables for the pins |
| core_rst | output | 1 | Reset to the core while external test is active |

## Verification
The first serial output bit of a scan is visible after the falling edge that follows the rising edge entering the shift state. Each later bit appears one falling edge after the rising edge that shifted it. Changes to the instruction, the core reset output and the pin outputs all appear on the falling edge in the update state. The driver therefore advances one full clock per step, samples one time unit after the falling edge, and queues every expected value. A separate monitor process pops each queued value against the observed port value. The asynchronous test reset is sampled half a time unit after it is driven, with no clock edge in between.

// File: rtl/jtag_tdp_pkg.sv
`timescale 1ns/1ps
package jtag_tdp_pkg;

   typedef enum logic [3:0] {
      ST_RESET,   ST_IDLE,
      ST_SEL_DR,  ST_CAP_DR,  ST_SHF_DR,  ST_EX1_DR,
      ST_PAU_DR,  ST_EX2_DR,  ST_UPD_DR,
      ST_SEL_IR,  ST_CAP_IR,  ST_SHF_IR,  ST_EX1_IR,
      ST_PAU_IR,  ST_EX2_IR,  ST_UPD_IR
   } tap_state_e;

   localparam int unsigned ID_W = 32;

   function automatic tap_state_e tap_next(tap_state_e s, logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
   import jtag_tdp_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e st_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st_q <= ST_RESET;
      else         st_q <= tap_next(st_q, tms);
   end

   assign state = st_q;

   AST_TMS_FIVE: assert property (@(posedge tck) disable iff (!trst_n)
      (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
         |=> (st_q == ST_RESET)); // R2

endmodule

// File: rtl/jtag_instr_reg.sv
`timescale 1ns/1ps
module jtag_instr_reg
   import jtag_tdp_pkg::*;
#(
   parameter int unsigned            IR_W       = 4,
   parameter logic [IR_W-1:0]        RESET_CODE = '1
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_so
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

   logic [IR_W-1:0] sh_q;
   logic [IR_W-1:0] act_q;

   if (IR_W < 2) begin : g_bad_width
      $error("instruction register needs at least two bits");
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  sh_q <= '0;
      else if (state == ST_CAP_IR)  sh_q <= CAP_PAT;
      else if (state == ST_SHF_IR)  sh_q <= {tdi, sh_q[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                  act_q <= RESET_CODE;
      else if (state == ST_RESET)   act_q <= RESET_CODE;
      else if (state == ST_UPD_IR)  act_q <= sh_q;
   end

   assign ir_q  = act_q;
   assign ir_so = sh_q[0];

   AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_IR) |=> (sh_q[1:0] == 2'b01)); // R3

endmodule

// File: rtl/jtag_bscan_reg.sv
`timescale 1ns/1ps
module jtag_bscan_reg #(
   parameter int unsigned NPINS = 4,
   localparam int unsigned CHAIN_L = 3 * NPINS,
   localparam int unsigned UPD_L   = 2 * NPINS
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tdi,
   input  logic               cap_en,
   input  logic               shf_en,
   input  logic               upd_en,
   input  logic [CHAIN_L-1:0] par_in,
   output logic               so,
   output logic [UPD_L-1:0]   upd_q
);

   logic [CHAIN_L-1:0] sh_q;
   logic [UPD_L-1:0]   hold_q;

   if (NPINS < 1) begin : g_bad_pins
      $error("boundary chain needs at least one pin");
   end

   // capture and shift stage, one flop per cell
   for (genvar c = 0; c < CHAIN_L; c++) begin : g_cell
      logic nxt;
      if (c == CHAIN_L - 1) begin : g_head
         assign nxt = tdi;
      end else begin : g_body
         assign nxt = sh_q[c+1];
      end
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)     sh_q[c] <= 1'b0;
         else if (cap_en) sh_q[c] <= par_in[c];
         else if (shf_en) sh_q[c] <= nxt;
      end
   end

   // update stage only for cells that drive pins
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)     hold_q <= '0;
      else if (upd_en) hold_q <= sh_q[CHAIN_L-1:NPINS];
   end

   assign so    = sh_q[0];
   assign upd_q = hold_q;

   AST_BSR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
      cap_en |=> (sh_q == $past(par_in))); // R7

endmodule

// File: rtl/jtag_tdp.sv
`timescale 1ns/1ps
module jtag_tdp
   import jtag_tdp_pkg::*;
#(
   parameter int unsigned  NPINS      = 4,
   parameter int unsigned  IR_W       = 4,
   parameter bit           HAS_IDCODE = 1'b1,
   parameter logic [31:0]  IDCODE     = 32'h0B37_41C5
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_oe,
   input  logic [NPINS-1:0] core_out,
   input  logic [NPINS-1:0] core_oe,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             core_rst
);

   localparam int unsigned     CHAIN_L   = 3 * NPINS;
   localparam int unsigned     UPD_L     = 2 * NPINS;
   localparam logic [IR_W-1:0] OP_EXTEST = '0;
   localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);
   localparam logic [IR_W-1:0] OP_IDCODE = IR_W'(2);
   localparam logic [IR_W-1:0] OP_BYPASS = '1;
   localparam logic [IR_W-1:0] RST_OP    = HAS_IDCODE ? OP_IDCODE : OP_BYPASS;

   if (HAS_IDCODE && (IDCODE[0] != 1'b1)) begin : g_bad_id
      $error("identification word must have bit 0 set");
   end

   tap_state_e          st;
   logic [IR_W-1:0]     ir;
   logic                ir_so;
   logic                bsr_so, id_so, dr_so;
   logic                byp_q;
   logic [UPD_L-1:0]    upd;
   logic                sel_ext, sel_smp, sel_id, sel_bsr, sel_byp;
   logic                tdo_q, oe_q;

   jtag_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (st)
   );

   jtag_instr_reg #(.IR_W(IR_W), .RESET_CODE(RST_OP)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .state  (st),
      .ir_q   (ir),
      .ir_so  (ir_so)
   );

   // instruction decode; unknown codes fall through to bypass
   assign sel_ext = (ir == OP_EXTEST);
   assign sel_smp = (ir == OP_SAMPLE);
   assign sel_id  = HAS_IDCODE && (ir == OP_IDCODE);
   assign sel_bsr = sel_ext || sel_smp;
   assign sel_byp = !sel_bsr && !sel_id;

   jtag_bscan_reg #(.NPINS(NPINS)) u_bsr (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .cap_en (sel_bsr && (st == ST_CAP_DR)),
      .shf_en (sel_bsr && (st == ST_SHF_DR)),
      .upd_en (sel_bsr && (st == ST_UPD_DR)),
      .par_in ({core_oe, core_out, pin_in}),
      .so     (bsr_so),
      .upd_q  (upd)
   );

   if (HAS_IDCODE) begin : g_id
      logic [ID_W-1:0] id_sh;
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)                          id_sh <= '0;
         else if (sel_id && st == ST_CAP_DR)   id_sh <= IDCODE;
         else if (sel_id && st == ST_SHF_DR)   id_sh <= {tdi, id_sh[ID_W-1:1]};
      end
      assign id_so = id_sh[0];
   end else begin : g_no_id
      assign id_so = 1'b0;
   end

   // single-cell bypass stage
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                         byp_q <= 1'b0;
      else if (sel_byp && st == ST_CAP_DR) byp_q <= 1'b0;
      else if (sel_byp && st == ST_SHF_DR) byp_q <= tdi;
   end

   assign dr_so = sel_bsr ? bsr_so : (sel_id ? id_so : byp_q);

   // serial output retimed to the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q  <= (st == ST_SHF_DR) || (st == ST_SHF_IR);
         tdo_q <= (st == ST_SHF_IR) ? ir_so :
                  (st == ST_SHF_DR) ? dr_so : 1'b0;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = oe_q;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign pin_out[p] = sel_ext ? upd[p]         : core_out[p];
      assign pin_oe[p]  = sel_ext ? upd[NPINS + p] : core_oe[p];
   end

   assign core_rst = sel_ext;

   AST_BYPASS_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
      (sel_byp && st == ST_SHF_DR) |=> (byp_q == $past(tdi))); // R4

   AST_TDO_ENABLE: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == ((st == ST_SHF_DR) || (st == ST_SHF_IR))); // R10

   AST_PINS_ISOLATED: assert property (@(posedge tck) disable iff (!trst_n)
      ((pin_out != core_out) || (pin_oe != core_oe)) |-> core_rst); // R8

endmodule

// File: tb/jtag_tdp_bench.sv
`timescale 1ns/1ps
module jtag_tdp_bench;

   localparam int unsigned NP  = 4;
   localparam logic [31:0] IDV = 32'h0B37_41C5;

   logic          tck = 1'b0;
   logic          trst_n = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic [NP-1:0] core_out, core_oe, pin_in;
   wire           tdo, tdo_oe, core_rst;
   wire  [NP-1:0] pin_out, pin_oe;

   always #2 tck = ~tck;

   jtag_tdp #(.NPINS(NP), .IDCODE(IDV)) u_jtag_tdp (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .tdo(tdo), .tdo_oe(tdo_oe),
      .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .core_rst(core_rst)
   );

   typedef struct { string tag; logic [63:0] val; } item_t;
   item_t exp_q[$];
   item_t act_q[$];
   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // driver side: expected item, then the observed port value
   task automatic push(string tag, logic [63:0] e, logic [63:0] a);
      item_t x;
      x.tag = tag; x.val = e; exp_q.push_back(x);
      x.val = a;   act_q.push_back(x);
   endtask

   // monitor: pops and compares
   initial begin
      item_t e;
      item_t a;
      forever begin
         wait (act_q.size() > 0);
         e = exp_q.pop_front();
         a = act_q.pop_front();
         n_chk++;
         if (e.val !== a.val) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", e.tag, a.val, e.val);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge tck);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic step(logic m, logic d);
      tms = m; tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   // from Run-Test/Idle, scan n bits and return to Run-Test/Idle
   task automatic scan(bit is_ir, int n, logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      step(1, 0);
      if (is_ir) step(1, 0);
      step(0, 0);
      step(0, 0);
      push("R10 enable in shift", 1, tdo_oe);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         step(i == n - 1, din[i]);
      end
      push("R10 enable off in exit", 0, tdo_oe);
      step(1, 0);
      step(0, 0);
   endtask

   initial begin
      logic [63:0] r;
      core_out = 4'b1010; core_oe = 4'b1100; pin_in = 4'b0110;
      repeat (3) @(negedge tck);
      #1;
      push("R10 reset enable", 0, tdo_oe);
      push("R1 reset core_rst", 0, core_rst);
      push("R1 reset pins", {core_oe, core_out}, {pin_oe, pin_out});
      trst_n = 1'b1;
      step(0, 0);

      scan(0, 32, 64'h0, r);
      push("R6 idcode after reset", IDV, r);

      scan(1, 4, 64'hF, r);
      push("R3 ir capture pattern", 4'b0001, r[3:0]);
      push("R3 bypass no core reset", 0, core_rst);
      scan(0, 8, 64'hA5, r);
      push("R4 bypass delay", 8'h4A, r[7:0]);

      scan(1, 4, 64'h6, r);
      scan(0, 8, 64'h3C, r);
      push("R5 undefined as bypass", 8'h78, r[7:0]);

      scan(1, 4, 64'h1, r);
      scan(0, 12, 64'hF50, r);
      push("R7 sample capture", 12'hCA6, r[11:0]);
      push("R8 pins follow core", {core_oe, core_out}, {pin_oe, pin_out});
      push("R8 no core reset", 0, core_rst);

      scan(1, 4, 64'h0, r);
      push("R9 core reset in extest", 1, core_rst);
      push("R9 preloaded pins", {4'b1111, 4'b0101}, {pin_oe, pin_out});

      pin_in = 4'b1001;
      scan(0, 12, 64'h3C0, r);
      push("R7 extest capture", 12'hCA9, r[11:0]);
      push("R9 updated pins", {4'b0011, 4'b1100}, {pin_oe, pin_out});
      push("R9 reset held", 1, core_rst);

      trst_n = 1'b0;
      #0.5;
      push("R1 async reset core_rst", 0, core_rst);
      push("R1 async reset pins", {core_oe, core_out}, {pin_oe, pin_out});
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      step(0, 0);

      scan(1, 4, 64'h0, r);
      push("R9 extest again", 1, core_rst);
      for (int k = 0; k < 5; k++) step(1, 0);
      push("R2 five tms high clears", 0, core_rst);
      step(0, 0);
      scan(0, 32, 64'h0, r);
      push("R2 idcode restored", IDV, r);

      done = 1'b1;
      wait (act_q.size() == 0);
      #1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule